// File: doc/BRIEF.md
# Paged Program Sequencer with Return Stack

This block owns the program counter of a small 4-bit controller with an 11-bit program address space. Each cycle where `op_valid` is high, it takes one control operation that has already been decoded, together with that operation's address field, and computes the next program address. The operations are:

- plain advance by one or two words;
- absolute jump;
- jump inside the current 256-word page, with the low byte computed from the E and AC nibbles;
- call into a small zero-page table;
- full call;
- return;
- return from interrupt;
- interrupt entry;
- same-page conditional branches.

A branch tests one selected bit of the accumulator, of the data-memory nibble or of the port nibble, and can be taken on a one or on a zero. A separate branch tests the timer flag and clears it when it is taken.

Return addresses are kept on an internal 8-entry hardware stack. Interrupt entry saves the carry and zero flags. Return from interrupt hands the saved flags back to the datapath with a one-cycle load strobe. A bank-change operation arms a prefix. The prefix is reported to the rest of the chip only while the very next operation executes, and only if that operation is a jump, an I/O operation or a branch.

Top module: `flow_sequencer`

## Requirements
- R1: After reset, `pc` is 0, the stack is empty, and `tmr_flag`, `stk_ovf`, `bank_hit`, `flags_ld`, `cf_out` and `zf_out` are all 0.
- R2: With `op_valid` low, `pc` holds. Codes 0 (step), 1 (I/O), 2 (bank change) and any code from 14 to 15 advance `pc` by 2 when `op_len2` is 1 and by 1 otherwise, modulo 2048.
- R3: Code 3 (jump) loads `pc` with all 11 bits of `addr_fld` on the next edge.
- R4: Code 4 (computed jump) keeps `pc[10:8]` and loads `pc[7:0]` with `{e_val, ac_val}`, with E in the upper nibble.
- R5: Code 5 (zero-page call) pushes `pc+1` and sets `pc` to `addr_fld[3:0]` placed in bits 5..2, with every other bit 0.
- R6: Code 6 (call) pushes `pc+2` and loads `addr_fld`. Code 7 (return) loads `pc` with the most recently pushed address and removes it from the stack.
- R7: Codes 9, 10 and 11 test bit `bit_sel` (0 is the LSB) of `ac_val`, `mem_val` and `port_val` respectively. The branch is taken when that bit equals `br_pol`. When taken, `pc` becomes `{(pc+2)[10:8], addr_fld[7:0]}`; when not taken, it becomes `pc+2`.
- R8: A `tmr_set` pulse sets `tmr_flag` on the next edge. Code 12 branches as R7 when `tmr_flag` is 1 and clears the flag. If `tmr_set` is high in the same cycle, the set wins.
- R9: Code 2 arms the bank prefix. While armed, `bank_hit` is high combinationally whenever `op_valid` is high with code 1, 3, 9, 10, 11 or 12. The prefix disarms after the next executed operation of any kind.
- R10: Code 13 (interrupt entry) pushes the current `pc`, loads `pc` with 0x004, and saves `cf_in` and `zf_in`.
- R11: Code 8 (interrupt return) pops `pc` as in R6. On the next edge it drives the saved flags on `cf_out` and `zf_out`, and raises `flags_ld` for exactly one cycle.
- R12: The stack holds 8 addresses. A push onto a full stack is dropped and sets `stk_ovf`, which stays set until reset. A pop from an empty stack loads `pc` with 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_valid | input | 1 | An operation executes this cycle |
| op_code | input | 4 | Decoded operation code (see requirements) |
| op_len2 | input | 1 | Non-control operation is two words long |
| bit_sel | input | 2 | Bit index for conditional branches |
| br_pol | input | 1 | Branch when the tested bit equals this value |
| addr_fld | input | 11 | Address field of the operation |
| e_val | input | 4 | E register value for computed jumps |
| ac_val | input | 4 | Accumulator value |
| mem_val | input | 4 | Data-memory nibble at the data pointer |
| port_val | input | 4 | Port nibble selected by the pointer low part |
| tmr_set | input | 1 | Timer overflow pulse |
| cf_in | input | 1 | Current carry flag, saved on interrupt entry |
| zf_in | input | 1 | Current zero flag, saved on interrupt entry |
| pc | output | 11 | Program counter |
| tmr_flag | output | 1 | Pending timer flag |
| bank_hit | output | 1 | Bank prefix applies to the current operation |
| cf_out | output | 1 | Restored carry flag |
| zf_out | output | 1 | Restored zero flag |
| flags_ld | output | 1 | One-cycle strobe to load the restored flags |
| stk_ovf | output | 1 | Sticky stack overflow |

## Verification
A wrong stack depth count or a corrupt stack entry is invisible until a return. At that point `pc` jumps to the wrong address on the edge after the pop, and the error spreads to every later same-page branch target. A wrong page taken from the branch-address incrementer shows up only when a branch sits in the last two words of a page, so those boundaries are driven on purpose. A timer flag or bank prefix that does not clear shows up on the very next eligible operation, as a branch taken twice or as `bank_hit` staying high.

// File: rtl/fseq_pkg.sv
package fseq_pkg;

   localparam int OP_W  = 4;
   localparam int ZP_SH = 2;   // zero-page target: field lands at bit 2
   localparam int ZP_W  = 4;   // four-bit zero-page field

   typedef enum logic [OP_W-1:0] {
      OP_STEP = 4'd0,
      OP_IO   = 4'd1,
      OP_BANK = 4'd2,
      OP_JMP  = 4'd3,
      OP_JEA  = 4'd4,
      OP_CZP  = 4'd5,
      OP_CALL = 4'd6,
      OP_RET  = 4'd7,
      OP_RETI = 4'd8,
      OP_BAC  = 4'd9,
      OP_BMEM = 4'd10,
      OP_BPRT = 4'd11,
      OP_BTMR = 4'd12,
      OP_INT  = 4'd13
   } op_e;

   function automatic logic is_branch(op_e o);
      return (o == OP_BAC) || (o == OP_BMEM) || (o == OP_BPRT) || (o == OP_BTMR);
   endfunction

   function automatic logic is_bank_user(op_e o);
      return is_branch(o) || (o == OP_JMP) || (o == OP_IO);
   endfunction

endpackage

// File: rtl/fseq_cond.sv
module fseq_cond
   import fseq_pkg::*;
#(
   parameter int NIB_W = 4
) (
   input  op_e                        op,
   input  logic [$clog2(NIB_W)-1:0]   bit_sel,
   input  logic                       pol,
   input  logic [NIB_W-1:0]           ac,
   input  logic [NIB_W-1:0]           mem,
   input  logic [NIB_W-1:0]           port,
   input  logic                       tmr,
   output logic                       hit
);

   if (NIB_W < 2) begin : g_bad_nib
      $error("fseq_cond: NIB_W must be at least 2");
   end

   logic [NIB_W-1:0] nib;
   logic             tbit;

   always_comb begin
      unique case (op)
         OP_BAC:  nib = ac;
         OP_BMEM: nib = mem;
         OP_BPRT: nib = port;
         default: nib = '0;
      endcase
   end

   assign tbit = nib[bit_sel];
   assign hit  = (op == OP_BTMR) ? tmr : (tbit == pol);

endmodule

// File: rtl/fseq_stack.sv
module fseq_stack #(
   parameter int W     = 11,
   parameter int DEPTH = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         push,
   input  logic         pop,
   input  logic [W-1:0] wdata,
   output logic [W-1:0] rdata,
   output logic         ovf
);

   localparam int DW = $clog2(DEPTH + 1);

   if (DEPTH < 1) begin : g_bad_depth
      $error("fseq_stack: DEPTH must be at least 1");
   end

   logic [DW-1:0]             depth;
   logic                      full;
   logic                      empty;
   logic [DEPTH-1:0][W-1:0]   tap;

   assign full  = (depth == DW'(DEPTH));
   assign empty = (depth == '0);

   for (genvar i = 0; i < DEPTH; i++) begin : g_ent
      logic [W-1:0] q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)                        q <= '0;
         else if (push && depth == DW'(i))  q <= wdata;
      end
      assign tap[i] = (depth == DW'(i + 1)) ? q : '0;
   end

   always_comb begin
      rdata = '0;
      for (int i = 0; i < DEPTH; i++) rdata = rdata | tap[i];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         depth <= '0;
         ovf   <= 1'b0;
      end else begin
         if (push && !full)       depth <= depth + DW'(1);
         else if (pop && !empty)  depth <= depth - DW'(1);
         if (push && full)        ovf   <= 1'b1;
      end
   end

endmodule

// File: rtl/fseq_nextpc.sv
module fseq_nextpc
   import fseq_pkg::*;
#(
   parameter int PC_W  = 11,
   parameter int NIB_W = 4
) (
   input  logic [PC_W-1:0]  pc,
   input  op_e              op,
   input  logic             len2,
   input  logic [PC_W-1:0]  addr,
   input  logic [NIB_W-1:0] e,
   input  logic [NIB_W-1:0] ac,
   input  logic             hit,
   input  logic [PC_W-1:0]  pop_data,
   input  logic [PC_W-1:0]  int_vec,
   output logic [PC_W-1:0]  npc,
   output logic             push_req,
   output logic             pop_req,
   output logic [PC_W-1:0]  push_data
);

   localparam int LO_W = 2 * NIB_W;

   if (PC_W <= LO_W) begin : g_bad_pcw
      $error("fseq_nextpc: PC_W must exceed the page width");
   end
   if (ZP_SH + ZP_W > PC_W) begin : g_bad_zp
      $error("fseq_nextpc: zero-page field does not fit");
   end

   logic [PC_W-1:0] pc1, pc2, zp_tgt, br_tgt;

   assign pc1 = pc + PC_W'(1);
   assign pc2 = pc + PC_W'(2);

   always_comb begin
      zp_tgt = '0;
      zp_tgt[ZP_SH +: ZP_W] = addr[ZP_W-1:0];
   end

   // page of a same-page branch comes from the word after the branch
   assign br_tgt = {pc2[PC_W-1:LO_W], addr[LO_W-1:0]};

   always_comb begin
      push_req  = 1'b0;
      pop_req   = 1'b0;
      push_data = pc1;
      npc       = len2 ? pc2 : pc1;
      unique case (op)
         OP_JMP:  npc = addr;
         OP_JEA:  npc = {pc[PC_W-1:LO_W], e, ac};
         OP_CZP: begin
            npc      = zp_tgt;
            push_req = 1'b1;
         end
         OP_CALL: begin
            npc       = addr;
            push_req  = 1'b1;
            push_data = pc2;
         end
         OP_RET, OP_RETI: begin
            npc     = pop_data;
            pop_req = 1'b1;
         end
         OP_BAC, OP_BMEM, OP_BPRT, OP_BTMR:
            npc = hit ? br_tgt : pc2;
         OP_INT: begin
            npc       = int_vec;
            push_req  = 1'b1;
            push_data = pc;
         end
         default: ;
      endcase
   end

endmodule

// File: rtl/flow_sequencer.sv
module flow_sequencer
   import fseq_pkg::*;
#(
   parameter int              PC_W      = 11,
   parameter int              NIB_W     = 4,
   parameter int              STK_DEPTH = 8,
   parameter logic [PC_W-1:0] INT_VEC   = 'h004
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     op_valid,
   input  logic [3:0]               op_code,
   input  logic                     op_len2,
   input  logic [$clog2(NIB_W)-1:0] bit_sel,
   input  logic                     br_pol,
   input  logic [PC_W-1:0]          addr_fld,
   input  logic [NIB_W-1:0]         e_val,
   input  logic [NIB_W-1:0]         ac_val,
   input  logic [NIB_W-1:0]         mem_val,
   input  logic [NIB_W-1:0]         port_val,
   input  logic                     tmr_set,
   input  logic                     cf_in,
   input  logic                     zf_in,
   output logic [PC_W-1:0]          pc,
   output logic                     tmr_flag,
   output logic                     bank_hit,
   output logic                     cf_out,
   output logic                     zf_out,
   output logic                     flags_ld,
   output logic                     stk_ovf
);

   op_e             op;
   logic            hit;
   logic [PC_W-1:0] npc, pop_data, push_data;
   logic            push_req, pop_req;
   logic [PC_W-1:0] pc_q;
   logic            tmr_q, arm_q, cf_sv, zf_sv, cf_q, zf_q, ld_q;
   logic            tmr_clr;

   assign op = op_e'(op_code);

   fseq_cond #(.NIB_W(NIB_W)) u_cond (
      .op      (op),
      .bit_sel (bit_sel),
      .pol     (br_pol),
      .ac      (ac_val),
      .mem     (mem_val),
      .port    (port_val),
      .tmr     (tmr_q),
      .hit     (hit)
   );

   fseq_nextpc #(.PC_W(PC_W), .NIB_W(NIB_W)) u_np (
      .pc        (pc_q),
      .op        (op),
      .len2      (op_len2),
      .addr      (addr_fld),
      .e         (e_val),
      .ac        (ac_val),
      .hit       (hit),
      .pop_data  (pop_data),
      .int_vec   (INT_VEC),
      .npc       (npc),
      .push_req  (push_req),
      .pop_req   (pop_req),
      .push_data (push_data)
   );

   fseq_stack #(.W(PC_W), .DEPTH(STK_DEPTH)) u_stk (
      .clk   (clk),
      .rst_n (rst_n),
      .push  (op_valid && push_req),
      .pop   (op_valid && pop_req),
      .wdata (push_data),
      .rdata (pop_data),
      .ovf   (stk_ovf)
   );

   assign tmr_clr = op_valid && (op == OP_BTMR) && tmr_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pc_q  <= '0;
         tmr_q <= 1'b0;
         arm_q <= 1'b0;
         cf_sv <= 1'b0;
         zf_sv <= 1'b0;
         cf_q  <= 1'b0;
         zf_q  <= 1'b0;
         ld_q  <= 1'b0;
      end else begin
         if (op_valid) begin
            pc_q  <= npc;
            arm_q <= (op == OP_BANK);
         end
         if (tmr_set)      tmr_q <= 1'b1;
         else if (tmr_clr) tmr_q <= 1'b0;
         if (op_valid && op == OP_INT) begin
            cf_sv <= cf_in;
            zf_sv <= zf_in;
         end
         ld_q <= op_valid && (op == OP_RETI);
         if (op_valid && op == OP_RETI) begin
            cf_q <= cf_sv;
            zf_q <= zf_sv;
         end
      end
   end

   assign pc       = pc_q;
   assign tmr_flag = tmr_q;
   assign bank_hit = arm_q && op_valid && is_bank_user(op);
   assign cf_out   = cf_q;
   assign zf_out   = zf_q;
   assign flags_ld = ld_q;

endmodule

// File: rtl/fseq_chk.sv
module fseq_chk
   import fseq_pkg::*;
#(
   parameter int PC_W  = 11,
   parameter int NIB_W = 4
) (
   input logic             clk,
   input logic             rst_n,
   input logic             op_valid,
   input logic [3:0]       op_code,
   input logic [PC_W-1:0]  addr_fld,
   input logic [NIB_W-1:0] e_val,
   input logic [NIB_W-1:0] ac_val,
   input logic             tmr_set,
   input logic [PC_W-1:0]  pc,
   input logic             tmr_flag,
   input logic             bank_hit,
   input logic             flags_ld,
   input logic             stk_ovf
);

   localparam int LO_W = 2 * NIB_W;

   p_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
      !op_valid |=> $stable(pc));

   p_jump_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (op_valid && op_code == 4'd3) |=> (pc == $past(addr_fld)));

   p_calc_jump_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (op_valid && op_code == 4'd4) |=>
         (pc == {$past(pc[PC_W-1:LO_W]), $past(e_val), $past(ac_val)}));

   p_zero_page_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (op_valid && op_code == 4'd5) |=>
         (pc[ZP_SH-1:0] == '0 && pc[PC_W-1:ZP_SH+ZP_W] == '0));

   p_timer_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (op_valid && op_code == 4'd12 && tmr_flag && !tmr_set) |=> !tmr_flag);

   p_timer_set_r8: assert property (@(posedge clk) disable iff (!rst_n)
      tmr_set |=> tmr_flag);

   p_bank_once_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (op_valid && op_code != 4'd2) |=> !bank_hit);

   p_flag_strobe_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (op_valid && op_code == 4'd8) |=> flags_ld);

   p_flag_pulse_r11: assert property (@(posedge clk) disable iff (!rst_n)
      !(op_valid && op_code == 4'd8) |=> !flags_ld);

   p_no_overflow_r12: assert property (@(posedge clk) disable iff (!rst_n)
      stk_ovf |=> stk_ovf);

endmodule

bind flow_sequencer fseq_chk #(.PC_W(PC_W), .NIB_W(NIB_W)) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .op_valid (op_valid),
   .op_code  (op_code),
   .addr_fld (addr_fld),
   .e_val    (e_val),
   .ac_val   (ac_val),
   .tmr_set  (tmr_set),
   .pc       (pc),
   .tmr_flag (tmr_flag),
   .bank_hit (bank_hit),
   .flags_ld (flags_ld),
   .stk_ovf  (stk_ovf)
);

// File: tb/sim_flow_sequencer.sv
`timescale 1ns/1ps
module sim_flow_sequencer;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        op_valid = 1'b0;
   logic [3:0]  op_code = '0;
   logic        op_len2 = 1'b0;
   logic [1:0]  bit_sel = '0;
   logic        br_pol = 1'b0;
   logic [10:0] addr_fld = '0;
   logic [3:0]  e_val = '0, ac_val = '0, mem_val = '0, port_val = '0;
   logic        tmr_set = 1'b0, cf_in = 1'b0, zf_in = 1'b0;
   logic [10:0] pc;
   logic        tmr_flag, bank_hit, cf_out, zf_out, flags_ld, stk_ovf;

   always #10 clk = ~clk;   // 50 MHz

   flow_sequencer u0 (
      .clk, .rst_n, .op_valid, .op_code, .op_len2, .bit_sel, .br_pol,
      .addr_fld, .e_val, .ac_val, .mem_val, .port_val, .tmr_set,
      .cf_in, .zf_in, .pc, .tmr_flag, .bank_hit, .cf_out, .zf_out,
      .flags_ld, .stk_ovf
   );

   int n_chk = 0;
   int n_bad = 0;

   // reference model state
   logic [10:0] m_pc;
   logic [10:0] m_stk [8];
   int          m_dep;
   logic        m_ovf, m_tmr, m_arm, m_cfs, m_zfs, m_cfo, m_zfo, m_fld;

   task automatic chk(input string req, input string what, input logic [10:0] act, input logic [10:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
      end
   endtask

   function automatic string tag_of(input int op);
      case (op)
         3:          return "R3";
         4:          return "R4";
         5:          return "R5";
         6, 7:       return "R6";
         8:          return "R11";
         9, 10, 11:  return "R7";
         12:         return "R8";
         13:         return "R10";
         default:    return "R2";
      endcase
   endfunction

   function automatic bit bank_user(input int op);
      return op == 1 || op == 3 || (op >= 9 && op <= 12);
   endfunction

   task automatic m_reset();
      m_pc = '0; m_dep = 0; m_ovf = 0; m_tmr = 0; m_arm = 0;
      m_cfs = 0; m_zfs = 0; m_cfo = 0; m_zfo = 0; m_fld = 0;
      for (int i = 0; i < 8; i++) m_stk[i] = '0;
   endtask

   task automatic m_push(input logic [10:0] d);
      if (m_dep == 8) m_ovf = 1;
      else begin m_stk[m_dep] = d; m_dep++; end
   endtask

   function automatic logic [10:0] m_pop();
      if (m_dep == 0) return '0;
      m_dep--;
      return m_stk[m_dep];
   endfunction

   task automatic check_regs(input string req);
      chk(req,  "pc",       pc,       m_pc);
      chk("R8",  "tmr_flag", 11'(tmr_flag), 11'(m_tmr));
      chk("R12", "stk_ovf",  11'(stk_ovf),  11'(m_ovf));
      chk("R11", "flags_ld", 11'(flags_ld), 11'(m_fld));
      chk("R11", "cf_out",   11'(cf_out),   11'(m_cfo));
      chk("R11", "zf_out",   11'(zf_out),   11'(m_zfo));
   endtask

   // called just after a falling edge; returns just after the next one
   task automatic run(input bit v, input int op, input logic [10:0] a = '0,
                      input bit l2 = 0, input logic [1:0] bs = '0, input bit pol = 0,
                      input logic [3:0] e = '0, input logic [3:0] ac = '0,
                      input logic [3:0] mem = '0, input logic [3:0] prt = '0,
                      input bit ts = 0, input bit cf = 0, input bit zf = 0);
      logic [10:0] p1, p2;
      logic [3:0]  nib;
      bit          taken, clr;
      op_valid = v; op_code = 4'(op); addr_fld = a; op_len2 = l2; bit_sel = bs;
      br_pol = pol; e_val = e; ac_val = ac; mem_val = mem; port_val = prt;
      tmr_set = ts; cf_in = cf; zf_in = zf;
      #1;
      chk("R9", "bank_hit", 11'(bank_hit), 11'(m_arm && v && bank_user(op)));
      p1 = m_pc + 11'd1; p2 = m_pc + 11'd2; clr = 0; m_fld = 0;
      if (v) begin
         case (op)
            3:  m_pc = a;
            4:  m_pc = {m_pc[10:8], e, ac};
            5:  begin m_push(p1); m_pc = {5'b0, a[3:0], 2'b00}; end
            6:  begin m_push(p2); m_pc = a; end
            7:  m_pc = m_pop();
            8:  begin m_pc = m_pop(); m_cfo = m_cfs; m_zfo = m_zfs; m_fld = 1; end
            9, 10, 11: begin
               nib   = (op == 9) ? ac : (op == 10) ? mem : prt;
               taken = (nib[bs] == pol);
               m_pc  = taken ? {p2[10:8], a[7:0]} : p2;
            end
            12: begin
               taken = m_tmr;
               clr   = m_tmr;
               m_pc  = taken ? {p2[10:8], a[7:0]} : p2;
            end
            13: begin m_push(m_pc); m_pc = 11'h004; m_cfs = cf; m_zfs = zf; end
            default: m_pc = l2 ? p2 : p1;
         endcase
         m_arm = (op == 2);
      end
      if (ts) m_tmr = 1;
      else if (clr) m_tmr = 0;
      @(negedge clk);
      check_regs(v ? tag_of(op) : "R2");
   endtask

   task automatic do_reset();
      op_valid = 0; tmr_set = 0;
      rst_n = 0;
      m_reset();
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1;
      #1;
      check_regs("R1");
      chk("R1", "bank_hit", 11'(bank_hit), 11'd0);
   endtask

   initial begin : watchdog
      repeat (200000) @(posedge clk);
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

   initial begin : main
      void'($urandom(32'h5EC0_0042));
      do_reset();
      // directed corner cases
      run(1, 3, 11'h5A3);                         // R3 jump
      run(1, 4, '0, 0, 0, 0, 4'hC, 4'h7);          // R4 -> 0x5C7
      run(1, 0, '0, 0);                           // R2 +1
      run(1, 1, '0, 1);                           // R2 +2
      run(0, 3, 11'h111);                         // R2 hold
      run(1, 5, 11'h7FF);                         // R5 -> 0x03C
      run(1, 6, 11'h7FE);                         // R6 call
      run(1, 7);                                  // R6 return
      run(1, 7);
      run(1, 3, 11'h6FE);                         // R7 page boundary
      run(1, 9, 11'h012, 0, 2'd2, 1, '0, 4'b0100); // R7 AC taken -> 0x712
      run(1, 10, 11'h055, 0, 2'd0, 1, '0, '0, 4'b1110); // R7 mem not taken
      run(1, 11, 11'h0AA, 0, 2'd3, 0, '0, '0, '0, 4'b0111); // R7 port on zero
      run(1, 12, 11'h033);                        // R8 flag clear: not taken
      run(1, 0, '0, 0, 0, 0, '0, '0, '0, '0, 1);   // R8 set
      run(1, 12, 11'h044);                        // R8 taken, clears
      run(1, 12, 11'h044);                        // R8 not taken again
      run(1, 2);                                  // R9 arm
      run(1, 3, 11'h200);                         // R9 hit
      run(1, 3, 11'h210);                         // R9 lapsed
      run(1, 2);
      run(1, 0);                                  // R9 consumed by step
      run(1, 9, 11'h000);                         // R9 no hit
      run(1, 13, '0, 0, 0, 0, '0, '0, '0, '0, 0, 1, 0); // R10
      run(1, 8);                                  // R11
      run(1, 0);                                  // R11 strobe drops
      for (int i = 0; i < 9; i++) run(1, 6, 11'(i * 37));   // R12 overflow
      for (int i = 0; i < 10; i++) run(1, 7);              // R12 empty pop
      // random phase after a fresh reset
      do_reset();
      for (int i = 0; i < 4000; i++) begin
         run(($urandom % 8) != 0, int'($urandom % 16), 11'($urandom),
             1'($urandom), 2'($urandom), 1'($urandom), 4'($urandom),
             4'($urandom), 4'($urandom), 4'($urandom),
             ($urandom % 8) == 0, 1'($urandom), 1'($urandom));
      end
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

endmodule